// File: doc/BRIEF.md
# Key Event Queue with Overflow Handling

This block holds keypad and general-purpose-input events until a host reads them out over a register interface. A scanner pushes each 8-bit event code with a one-cycle valid strobe. The host pops the oldest entry with a read strobe and also sees the number of stored events. Ten entries are held. Each code keeps its meaning as written: bit 7 marks a press (1) or a release (0), and bits 6:0 give the event number. Keypad keys use numbers 1 to 80 and general-purpose-input events use 97 to 114.

A configuration input decides what happens when an event arrives while all ten slots are full. In drop mode the new event is thrown away. In shift mode the oldest event is discarded and the new one is stored. In both modes the block sends a one-cycle overflow pulse to the interrupt logic. An empty flag lets the interrupt logic tell whether the key-event status may clear. The read strobe carries a register index from 0 to 9. The index does not change which entry comes out: the queue always returns the oldest one.

Top module: `key_event_fifo`

## Requirements
- R1: After reset the count is 0, the empty flag is 1, the read data is 0x00 and the overflow pulse is 0.
- R2: Each push into a queue that is not full stores the 8-bit code. The count rises by one on the next cycle.
- R3: A pop of a queue that is not empty places the oldest stored code, bit for bit, on the read data in the cycle after the strobe. The count falls by one in that same cycle. Bit 7 (press = 1) and bits 6:0 (event number: 1..80 for keys, 97..114 for inputs) are returned exactly as pushed.
- R4: Entries come out in arrival order whatever read index (0..9) comes with the pop.
- R5: A pop of an empty queue returns 0x00 on the read data and leaves the count at 0.
- R6: A push and a pop in the same cycle on a queue that is not full both take effect, and the count does not change.
- R7: With overflow mode 0 (drop), a push into a full queue is discarded. The ten stored codes and their order stay the same.
- R8: With overflow mode 1 (shift), a push into a full queue discards the oldest entry and appends the new code. The count stays at 10.
- R9: The overflow output pulses high for exactly the one cycle after a push into a full queue with no pop in that cycle, in either mode. It is low at all other times.
- R10: The empty output is 1 exactly when the count is 0. The full output is 1 exactly when the count is 10. The count never exceeds 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld_i | input | 1 | Event push strobe |
| push_code_i | input | 8 | Event code: bit 7 press/release, bits 6:0 event number |
| ovf_shift_i | input | 1 | 1: shift out the oldest entry on a full push; 0: drop the new event |
| pop_i | input | 1 | Host read strobe; pops the oldest entry |
| rd_sel_i | input | 4 | Event register index of the read, 0..9 (does not affect ordering) |
| rd_data_o | output | 8 | Code returned by the last pop |
| count_o | output | 4 | Number of stored events, 0..10 |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
Every result is registered once. Read data, count, flags and the overflow pulse all reflect a strobe one clock edge after the edge that samples it. The bench drives inputs on the falling edge. For each cycle it queues the expected count, flags, overflow value and, for a pop, the expected code, all taken from a model queue. A monitor samples one nanosecond after the next rising edge and compares against the head of that scoreboard. The stimulus covers reset, fills and drains, mixed read indices, empty reads, a simultaneous push and pop, and full pushes in both modes.

// File: rtl/kef_pkg.sv
package kef_pkg;
  localparam int KEF_CODE_W = 8;
  typedef logic [KEF_CODE_W-1:0] kev_code_t;
  localparam kev_code_t KEF_EMPTY_CODE = '0;
endpackage

// File: rtl/kef_ctrl.sv
module kef_ctrl #(
  parameter int DEPTH = 10,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          shift_mode_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic          pop_ok_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full_w, empty_w;
  logic          do_pop, do_push, do_shift, head_adv;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PW'(1);
  endfunction

  assign full_w  = (cnt_q == FULL_CNT);
  assign empty_w = (cnt_q == '0);

  always_comb begin
    do_pop   = pop_i && !empty_w;
    do_push  = push_i && (!full_w || do_pop);
    do_shift = push_i && full_w && !pop_i && shift_mode_i;
    ovf_d    = push_i && full_w && !pop_i;
    head_adv = do_pop || do_shift;
    head_d   = head_adv ? ptr_inc(head_q) : head_q;
    tail_d   = (do_push || do_shift) ? ptr_inc(tail_q) : tail_q;
    cnt_d    = cnt_q;
    if (do_push && !do_pop) begin
      cnt_d = cnt_q + CW'(1);
    end else if (do_pop && !do_push) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  assign wr_en_o  = do_push || do_shift;
  assign wr_ptr_o = tail_q;
  assign rd_ptr_o = head_q;
  assign pop_ok_o = do_pop;
  assign count_o  = cnt_q;
  assign empty_o  = empty_w;
  assign full_o   = full_w;
  assign ovf_o    = ovf_q;

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R9
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_w && !pop_i) |=> ovf_o);
  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_w && !pop_i && !shift_mode_i) |=> ($stable(head_q) && $stable(tail_q)));
  // R6
  pushpop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !full_w && !empty_w) |=> $stable(cnt_q));
  // R8
  shift_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_w && !pop_i && shift_mode_i) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/kef_store.sv
module kef_store
  import kef_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_ptr_i,
  input  kev_code_t     wr_code_i,
  input  logic [PW-1:0] rd_ptr_i,
  output kev_code_t     head_code_o
);
  kev_code_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en_i && (wr_ptr_i == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_en) begin
        slot_q[g] <= wr_code_i;
      end
    end
  end

  always_comb begin
    head_code_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_ptr_i == PW'(i)) head_code_o = slot_q[i];
    end
  end
endmodule

// File: rtl/kef_rdport.sv
module kef_rdport
  import kef_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pop_req_i,
  input  logic      pop_ok_i,
  input  kev_code_t head_code_i,
  output kev_code_t rd_data_o
);
  kev_code_t rd_q, rd_d;

  always_comb begin
    rd_d = rd_q;
    if (pop_req_i) rd_d = pop_ok_i ? head_code_i : KEF_EMPTY_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (pop_req_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && !pop_ok_i) |=> (rd_data_o == KEF_EMPTY_CODE));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_req_i |=> $stable(rd_data_o));
endmodule

// File: rtl/key_event_fifo.sv
module key_event_fifo
  import kef_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_vld_i,
  input  logic [KEF_CODE_W-1:0] push_code_i,
  input  logic                  ovf_shift_i,
  input  logic                  pop_i,
  input  logic [PW-1:0]         rd_sel_i,
  output logic [KEF_CODE_W-1:0] rd_data_o,
  output logic [CW-1:0]         count_o,
  output logic                  empty_o,
  output logic                  full_o,
  output logic                  ovf_o
);
  logic          wr_en, pop_ok;
  logic [PW-1:0] wr_ptr, rd_ptr;
  kev_code_t     head_code;

  kef_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .push_i(push_vld_i), .pop_i(pop_i),
    .shift_mode_i(ovf_shift_i), .wr_en_o(wr_en), .wr_ptr_o(wr_ptr),
    .rd_ptr_o(rd_ptr), .pop_ok_o(pop_ok), .count_o(count_o),
    .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o)
  );

  kef_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_ptr_i(wr_ptr),
    .wr_code_i(push_code_i), .rd_ptr_i(rd_ptr), .head_code_o(head_code)
  );

  kef_rdport i_rdport (
    .clk(clk), .rst_n(rst_n), .pop_req_i(pop_i), .pop_ok_i(pop_ok),
    .head_code_i(head_code), .rd_data_o(rd_data_o)
  );

  // R4
  rd_sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (rd_sel_i <= PW'(DEPTH - 1)));
  // R10
  flag_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o == (count_o == '0)) && !(empty_o && full_o));
  // R2
  push_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld_i && !pop_i && !full_o) |=> (count_o == $past(count_o) + CW'(1)));
endmodule

// File: tb/test_key_event_fifo.sv
`timescale 1ns/1ps
module test_key_event_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_vld_i = 1'b0;
  logic [7:0] push_code_i = '0;
  logic       ovf_shift_i = 1'b0;
  logic       pop_i = 1'b0;
  logic [3:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;
  logic [3:0] count_o;
  logic       empty_o, full_o, ovf_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       popped;
    logic [7:0] rd;
    int         cnt;
    logic       ovf;
    string      req;
  } exp_t;

  logic [7:0] mdl[$];
  exp_t       sb[$];

  always #2.5 clk = ~clk;

  key_event_fifo i_key_event_fifo (
    .clk(clk), .rst_n(rst_n), .push_vld_i(push_vld_i), .push_code_i(push_code_i),
    .ovf_shift_i(ovf_shift_i), .pop_i(pop_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .count_o(count_o), .empty_o(empty_o),
    .full_o(full_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected results queued for the monitor
  task automatic drive(input bit push, input logic [7:0] code, input bit pop,
                       input logic [3:0] sel, input bit mode, input string req);
    exp_t e;
    bit full;
    @(negedge clk);
    push_vld_i = push; push_code_i = code; pop_i = pop; rd_sel_i = sel; ovf_shift_i = mode;
    full = (mdl.size() == 10);
    e.popped = pop;
    e.rd = 8'h00;
    e.ovf = push && full && !pop;
    e.req = req;
    if (pop && mdl.size() > 0) e.rd = mdl.pop_front();
    if (push) begin
      if (mdl.size() < 10) mdl.push_back(code);
      else if (mode) begin void'(mdl.pop_front()); mdl.push_back(code); end
    end
    e.cnt = mdl.size();
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 4'd0, 0, "R1");
  endtask

  // monitor: compares each cycle's outputs one edge after the stimulus
  always @(posedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      #1;
      if (e.popped) chk(rd_data_o == e.rd, {e.req, " rd_data"}, rd_data_o, e.rd);
      chk(count_o == 4'(e.cnt), {e.req, " count"}, count_o, e.cnt);
      chk(ovf_o == e.ovf, "R9 ovf", ovf_o, e.ovf);
      chk(empty_o == (e.cnt == 0), "R10 empty", empty_o, e.cnt == 0);
      chk(full_o == (e.cnt == 10), "R10 full", full_o, e.cnt == 10);
    end
  end

  initial begin
    fork
      begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(empty_o == 1, "R1 empty", empty_o, 1);
    chk(rd_data_o == 0, "R1 rd_data", rd_data_o, 0);
    chk(ovf_o == 0, "R1 ovf", ovf_o, 0);
    @(negedge clk); rst_n = 1'b1;
    // R5 empty read
    drive(0, 8'h00, 1, 4'd3, 0, "R5");
    drive(0, 8'h00, 1, 4'd0, 0, "R5");
    // R2 fill with keys (press 0x80|n) and input events (97..114)
    for (int i = 0; i < 5; i++) drive(1, 8'h80 | 8'(i + 1), 0, 4'd0, 0, "R2");
    for (int i = 0; i < 5; i++) drive(1, 8'(97 + i), 0, 4'd0, 0, "R2");
    // R7 drop mode on full
    drive(1, 8'hF2, 0, 4'd0, 0, "R7");
    drive(1, 8'h50, 0, 4'd0, 0, "R7");
    idle(1);
    // R3 R4 drain with varied indices
    for (int i = 0; i < 4; i++) drive(0, 8'h00, 1, 4'(9 - 2 * i), 0, "R4");
    // R6 simultaneous push/pop
    drive(1, 8'h33, 1, 4'd5, 0, "R6");
    drive(1, 8'hB4, 1, 4'd1, 0, "R6");
    // refill to full, then R8 shift mode
    for (int i = 0; i < 4; i++) drive(1, 8'h40 + 8'(i), 0, 4'd0, 1, "R2");
    drive(1, 8'hE1, 0, 4'd0, 1, "R8");
    drive(1, 8'h72, 0, 4'd0, 1, "R8");
    // full with push and pop together: no overflow
    drive(1, 8'h11, 1, 4'd2, 1, "R9");
    // R3 drain all, then empty reads
    for (int i = 0; i < 10; i++) drive(0, 8'h00, 1, 4'(i), 0, "R3");
    drive(0, 8'h00, 1, 4'd7, 0, "R5");
    // push and pop on empty: push only
    drive(1, 8'h01, 1, 4'd0, 0, "R5");
    drive(0, 8'h00, 1, 4'd0, 0, "R3");
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule